// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets clocked logic read and write one word at a time in an external asynchronous static RAM. The RAM has a 17-bit word address and an 8-bit data bus shared by both directions. A request (direction, address, write data) is offered on a valid/ready handshake. The sequencer then drives the active-low select, write and output strobes, the address, its own data output and the enable for that data output. It ends every access with a one-cycle done pulse, which carries the sampled word on a read.

Every strobe and pin output comes from a register. Each access has the same order of phases: a setup cycle, then either a write pulse or a read wait, then a recovery window in which the RAM is deselected. After that the request port reopens. Three parameters set the write-pulse, read-wait and recovery lengths in clock cycles, so one netlist can serve parts of different speed grades and different clock rates. Output enable is held high while the sequencer drives the bus. The recovery window keeps the sequencer's driver off until the RAM has had time to release the bus after a read.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset the strobes `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only when no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Request inputs that change while `req_ready` is 0 have no effect on the access in progress or on memory contents.
- R3: A write (`req_write`=1) drives `mem_we_n` low for exactly WR_PULSE_CYC cycles while `mem_cs_n` is low. `mem_oe_n` stays 1 throughout. `mem_dq_oe` is 1 from the setup cycle until one cycle after `mem_we_n` returns high.
- R4: `mem_addr` shows the request address from the cycle after acceptance. It does not change while `mem_we_n` is low.
- R5: A read (`req_write`=0) holds `mem_cs_n` low, `mem_we_n` high and `mem_oe_n` low for RD_WAIT_CYC cycles. `mem_dq_in` is sampled at the end of the last of those cycles and presented on `rsp_rdata` with `rsp_valid`.
- R6: `rsp_valid` is a pulse exactly one cycle wide for every access, read or write.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. It turns on only after `mem_oe_n` has been high for more than TURN_CYC cycles.
- R8: `mem_cs_n` is 1 whenever `req_ready` is 1, so the RAM is deselected when idle.
- R9: `rsp_valid` rises 1+WR_PULSE_CYC cycles after a write is accepted, and 1+RD_WAIT_CYC cycles after a read is accepted. The port reopens TURN_CYC cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request port open |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Word to write |
| rsp_valid | output | 1 | One-cycle access-done pulse |
| rsp_rdata | output | 8 | Word read (valid with rsp_valid after a read) |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_addr | output | 17 | RAM address lines |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable of the sequencer's data driver |
| mem_dq_in | input | 8 | Data read from the RAM bus |

## Verification
The bench runs a write directly after a read and checks that the driver stays off through the recovery window; a sequencer with a short or missing turnaround would switch on while the RAM model still drives, and the contention monitor would catch it. It changes the address and data while an access is busy. A sequencer that reloads its request registers mid-access would corrupt the word that was already written. It writes at the top address and with all-zero and all-one data, and counts the write-pulse width and latencies with non-default lengths. An off-by-one in the cycle counter would shift the done pulse or shorten the write strobe. It also watches that data is still driven on the cycle the write strobe rises, which a sequencer that dropped the zero-hold margin would fail.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_RWAIT   = 3'd3,
    ST_RECOVER = 3'd4
  } sramc_state_e;

  // Bits needed to count down from the longest phase length minus one.
  function automatic int cnt_bits(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // Cycles from the accepting edge to the done pulse.
  function automatic int done_latency(input int phase_len);
    return 1 + phase_len;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int WR_PULSE_CYC = 1,
  parameter int RD_WAIT_CYC  = 2,
  parameter int TURN_CYC     = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_write,
  output sramc_state_e state_q,
  output sramc_state_e state_d,
  output logic         accept,
  output logic         op_write_q
);

  localparam int CW = cnt_bits(WR_PULSE_CYC, RD_WAIT_CYC, TURN_CYC);

  logic          phase_load;
  logic [CW-1:0] phase_len;
  logic          phase_done;

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_valid)  state_d = ST_SETUP;
      ST_SETUP:   state_d = op_write_q ? ST_WPULSE : ST_RWAIT;
      ST_WPULSE:  if (phase_done) state_d = ST_RECOVER;
      ST_RWAIT:   if (phase_done) state_d = ST_RECOVER;
      ST_RECOVER: if (phase_done) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    phase_load = (state_d != state_q);
    case (state_d)
      ST_WPULSE:  phase_len = CW'(WR_PULSE_CYC - 1);
      ST_RWAIT:   phase_len = CW'(RD_WAIT_CYC - 1);
      ST_RECOVER: phase_len = CW'(TURN_CYC - 1);
      default:    phase_len = '0;
    endcase
  end

  sramc_timer #(.W(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_len),
    .expired  (phase_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) op_write_q <= req_write;
    end
  end

endmodule

// File: rtl/sramc_pins.sv
module sramc_pins
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sramc_state_e      state_q,
  input  sramc_state_e      state_d,
  input  logic              accept,
  input  logic              op_write_q,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic is_write;
  logic phase_end;
  logic drive_next;

  assign is_write   = accept ? req_write : op_write_q;
  assign phase_end  = (state_d == ST_RECOVER) &&
                      ((state_q == ST_WPULSE) || (state_q == ST_RWAIT));
  assign drive_next = (is_write && ((state_d == ST_SETUP) || (state_d == ST_WPULSE))) ||
                      ((state_q == ST_WPULSE) && (state_d == ST_RECOVER));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      mem_cs_n  <= !((state_d == ST_SETUP) || (state_d == ST_WPULSE) ||
                     (state_d == ST_RWAIT));
      mem_we_n  <= (state_d != ST_WPULSE);
      mem_oe_n  <= (state_d != ST_RWAIT);
      mem_dq_oe <= drive_next;
      rsp_valid <= phase_end;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (phase_end && (state_q == ST_RWAIT)) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int WR_PULSE_CYC = 1,
  parameter int RD_WAIT_CYC  = 2,
  parameter int TURN_CYC     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CHK_W = cnt_bits(WR_PULSE_CYC + 2, TURN_CYC + 2, 2) + 1;

  sramc_state_e state_q;
  sramc_state_e state_d;
  logic         accept;
  logic         op_write_q;

  assign req_ready = (state_q == ST_IDLE);

  sramc_seq #(
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .RD_WAIT_CYC  (RD_WAIT_CYC),
    .TURN_CYC     (TURN_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .state_q    (state_q),
    .state_d    (state_d),
    .accept     (accept),
    .op_write_q (op_write_q)
  );

  sramc_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .state_d    (state_d),
    .accept     (accept),
    .op_write_q (op_write_q),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // Observation counters for the assertions below.
  logic [CHK_W-1:0] we_low_cnt;
  logic [CHK_W-1:0] oe_high_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt  <= '0;
      oe_high_cnt <= '0;
    end else begin
      we_low_cnt  <= mem_we_n ? '0 : we_low_cnt + 1'b1;
      if (!mem_oe_n)                   oe_high_cnt <= '0;
      else if (oe_high_cnt != '1)      oe_high_cnt <= oe_high_cnt + 1'b1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe); // R1
  AST_READY_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> mem_cs_n); // R8
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) !mem_cs_n |-> !req_ready); // R2
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_oe_n && !mem_cs_n && mem_dq_oe); // R3
  AST_WP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> we_low_cnt == CHK_W'(WR_PULSE_CYC)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> mem_dq_oe); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> $stable(mem_addr)); // R4
  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> !mem_cs_n && mem_we_n); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_dq_oe) |-> oe_high_cnt > CHK_W'(TURN_CYC)); // R7

endmodule

// File: tb/sram_model.sv
module sram_model #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int DEPTH_BITS = 10
) (
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              din_en,
  output logic [DATA_W-1:0] dout,
  output logic              drive,
  output logic              conflict
);

  logic [DATA_W-1:0] cells [1 << DEPTH_BITS];
  logic              wr_strobe;

  assign wr_strobe = we_n | cs_n;
  assign drive     = !cs_n && we_n && !oe_n;
  assign dout      = drive ? cells[addr[DEPTH_BITS-1:0]] : '0;
  assign conflict  = drive && din_en;

  always_ff @(posedge wr_strobe) begin
    cells[addr[DEPTH_BITS-1:0]] <= din;
  end

endmodule

// File: tb/sramc_ctrl_bench.sv
module sramc_ctrl_bench;

  localparam int WP   = 2;
  localparam int RW   = 3;
  localparam int TURN = 2;
  localparam int NVEC = 11;

  // {write, address[16:0], data[7:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 17'h00000, 8'hA5},
    {1'b1, 17'h1FFFF, 8'h3C},
    {1'b1, 17'h00155, 8'h00},
    {1'b1, 17'h002AA, 8'hFF},
    {1'b0, 17'h00000, 8'h00},
    {1'b0, 17'h1FFFF, 8'h00},
    {1'b1, 17'h00155, 8'h81},
    {1'b0, 17'h002AA, 8'h00},
    {1'b0, 17'h00155, 8'h00},
    {1'b1, 17'h00000, 8'h5A},
    {1'b0, 17'h00000, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;
  logic        model_drive, model_conflict;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [int];

  always #10 clk = ~clk;

  sramc_ctrl #(
    .WR_PULSE_CYC (WP),
    .RD_WAIT_CYC  (RW),
    .TURN_CYC     (TURN)
  ) u_sramc_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  sram_model u_model (
    .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .addr(mem_addr),
    .din(mem_dq_out), .din_en(mem_dq_oe), .dout(mem_dq_in),
    .drive(model_drive), .conflict(model_conflict)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Cycle monitors, sampled at the falling edge.
  int err_contention = 0, err_oe_write = 0, err_addr = 0, err_wp = 0;
  int err_hold = 0, err_turn = 0, err_idle_cs = 0, err_pulse = 0;
  int we_cnt = 0, oe_gap = 100;
  logic [16:0] prev_addr = '0;
  logic prev_we_n = 1'b1, prev_dq_oe = 1'b0, prev_rsp = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (model_conflict || (mem_dq_oe && !mem_oe_n)) err_contention++;   // R7
      if (!mem_we_n && !mem_oe_n) err_oe_write++;                         // R3
      if (!mem_we_n && (mem_addr != prev_addr)) err_addr++;               // R4
      if (!mem_we_n && !mem_dq_oe) err_hold++;                            // R3
      if (mem_we_n && !prev_we_n && !mem_dq_oe) err_hold++;               // R3
      if (!mem_we_n) we_cnt++;
      else begin
        if (!prev_we_n && we_cnt != WP) err_wp++;                         // R3
        we_cnt = 0;
      end
      if (!mem_oe_n) oe_gap = 0;
      else if (oe_gap < 100) oe_gap++;
      if (mem_dq_oe && !prev_dq_oe && oe_gap <= TURN + 1) err_turn++;     // R7
      if (req_ready && !mem_cs_n) err_idle_cs++;                          // R8
      if (rsp_valid && prev_rsp) err_pulse++;                             // R6
      prev_addr  = mem_addr;
      prev_we_n  = mem_we_n;
      prev_dq_oe = mem_dq_oe;
      prev_rsp   = rsp_valid;
    end
  end

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int n;
    int exp_lat;
    @(negedge clk);
    check(req_ready, "R2 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_addr == a, "R4 address on pins", int'(mem_addr), int'(a));
    check(!req_ready && !mem_cs_n, "R2 busy after accept", int'(req_ready), 0);
    n = 0;
    while (!rsp_valid && n < 64) begin
      @(negedge clk);
      n++;
    end
    exp_lat = sramc_pkg::done_latency(wr ? WP : RW);
    check(n == exp_lat, "R9 done latency", n, exp_lat);
    if (wr) shadow[int'(a)] = d;
    else check(rsp_rdata == shadow[int'(a)], "R5 read data", int'(rsp_rdata), int'(shadow[int'(a)]));
    n = 0;
    while (!req_ready && n < 64) begin
      @(negedge clk);
      n++;
    end
    check(n == TURN, "R9 recovery length", n, TURN);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while held in reset and right after release
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
          int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_dq_oe && !rsp_valid, "R1 driver and done idle",
          int'({mem_dq_oe, rsp_valid}), 0);
    check(req_ready && mem_cs_n, "R1 ready and deselected",
          int'({req_ready, mem_cs_n}), 3);

    for (int i = 0; i < NVEC; i++) begin
      do_op(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);
    end

    // R2: request inputs altered while busy must not disturb the access
    do_op(1'b1, 17'h00010, 8'h11);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00020; req_wdata = 8'h22;
    @(posedge clk);
    @(negedge clk);
    req_addr = 17'h00010; req_wdata = 8'hEE;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b0;
    shadow[32'h20] = 8'h22;
    do_op(1'b0, 17'h00010, 8'h00);
    do_op(1'b0, 17'h00020, 8'h00);

    // back-to-back read then write exercises the turnaround window (R7)
    do_op(1'b0, 17'h00155, 8'h00);
    do_op(1'b1, 17'h00155, 8'h7E);
    do_op(1'b0, 17'h00155, 8'h00);

    repeat (4) @(negedge clk);
    check(err_contention == 0, "R7 bus contention", err_contention, 0);
    check(err_turn == 0, "R7 turnaround", err_turn, 0);
    check(err_oe_write == 0, "R3 output enable during write", err_oe_write, 0);
    check(err_wp == 0, "R3 write pulse width", err_wp, 0);
    check(err_hold == 0, "R3 data drive window", err_hold, 0);
    check(err_addr == 0, "R4 address stable in write", err_addr, 0);
    check(err_idle_cs == 0, "R8 deselected when idle", err_idle_cs, 0);
    check(err_pulse == 0, "R6 single-cycle done", err_pulse, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule